// File: doc/BRIEF.md
# Programmable Bus Event Detector

This block sits beside a processor core and watches its bus without taking part in it. It has no ready or stall output, so the core never waits on it and spends no cycles or memory on it. It sees the instruction-fetch address, the data-access address, the data value and a read/write qualifier. A bank of comparators checks every bus cycle. A debug host programs the comparators through a word-addressed register port. Each comparator matches on a masked address and, for data accesses, a masked data value. The kinds of access it responds to are selectable.

Each comparator sends its matches to any mix of three actions. It can raise a halt request to the core, bump a 16-bit occurrence counter, or fire a one-cycle pulse on an external trigger pin. A gated mode makes the halt wait until the counter reaches a programmed threshold. A halt on a fetch address works as a breakpoint in read-only code, where no instruction is patched. When no comparator uses the halt action, every match is still counted and pulsed while the core keeps running.

Top module: `busEventDetector`

## Requirements
- R1: After reset, haltReq and trigPulse are 0, eventCount is 0, every comparator is disabled and the global enable is 0. Bus traffic alone then causes no action.
- R2: A comparator with its fetch type enabled matches when fetchValid is 1 and ((fetchAddr XOR addrValue) AND addrMask) is zero. The data value is not used for a fetch match.
- R3: A comparator matches a data access when dataValid is 1 and the access type is enabled (read when dataWrite is 0, write when dataWrite is 1). Both the masked dataAddr compare and the masked dataValue compare must be zero.
- R4: Mask bits that are 0 exclude the matching address or data bit from the compare.
- R5: Config word bits are: 0 enable, 1 fetch, 2 read, 3 write, 4 halt action, 5 count action, 6 trigger action. Hits from all comparators in the same cycle are ORed per action, so the counter rises by at most one per cycle.
- R6: Every action appears on the outputs exactly one clock after the bus cycle that caused it.
- R7: trigPulse is high for one cycle per cycle that has a trigger-action match.
- R8: haltReq is a level. It stays high until the host writes the command word (address 0x01) with bit 0 set. The clear wins over a new halt in the same cycle.
- R9: eventCount rises by one per counted cycle and saturates at 0xFFFF. Writing command bit 1 sets it to 0, and that clear wins over a count in the same cycle.
- R10: Control bit 1 (address 0x00) selects gated halt. Halt-action hits then also count as occurrences. A halt is raised on any occurrence where count+1 is at least the threshold (address 0x02). The counter stops increasing once it equals or exceeds the threshold.
- R11: Control bit 0 is the global enable. While it is 0, no match changes haltReq, trigPulse or eventCount.
- R12: Register map, with word addresses: 0x00 control, 0x01 command (write-only, reads as 0), 0x02 threshold, 0x03 count (read-only). Comparator i sits at base 0x10+8*i, at offsets +0 address value, +1 address mask, +2 data value, +3 data mask, +4 config. Reads are combinational and return the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Instruction fetch in this cycle |
| fetchAddr | input | 32 | Fetch address |
| dataValid | input | 1 | Data access in this cycle |
| dataWrite | input | 1 | 1 for write, 0 for read |
| dataAddr | input | 32 | Data access address |
| dataValue | input | 32 | Data moved by the access |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 8 | Host register word address |
| regWdata | input | 32 | Host write data |
| regRdata | output | 32 | Host read data, combinational from regAddr |
| haltReq | output | 1 | Halt request level to the core |
| trigPulse | output | 1 | External trigger pulse |
| eventCount | output | 16 | Occurrence counter |

## Verification
The bus cycle and any register write are applied before a rising edge. Halt, trigger, counter and the effect of a write all become visible after that same edge, one clock later. Register reads are due in the same cycle as the address. The bench drives on the falling edge and updates its reference model on the rising edge. It compares all three outputs against the model on every falling edge. Directed checks are placed on the falling edge that follows the stimulating edge, and they cover threshold, saturation and clear-priority cases.

// File: rtl/bed_pkg.sv
package bed_pkg;
  localparam int REG_W    = 32;
  localparam int RA_W     = 8;
  localparam logic [RA_W-1:0] ADDR_CTRL   = 8'h00;
  localparam logic [RA_W-1:0] ADDR_CMD    = 8'h01;
  localparam logic [RA_W-1:0] ADDR_THRESH = 8'h02;
  localparam logic [RA_W-1:0] ADDR_COUNT  = 8'h03;
  localparam int CMP_BASE   = 16;
  localparam int CMP_STRIDE = 8;
  localparam int CFG_W      = 7;

  // bit 0 enable ... bit 6 trigger action
  typedef struct packed {
    logic actTrig;
    logic actCount;
    logic actHalt;
    logic onWrite;
    logic onRead;
    logic onFetch;
    logic enable;
  } cmpCfg_t;

  typedef struct packed {
    logic incCount;
    logic clrCount;
  } dpStrobe_t;
endpackage

// File: rtl/bed_cmp.sv
module bed_cmp
  import bed_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  cmpCfg_t         cfg,
  input  logic [AW-1:0]   addrVal,
  input  logic [AW-1:0]   addrMask,
  input  logic [DW-1:0]   dataVal,
  input  logic [DW-1:0]   dataMask,
  input  logic            fetchValid,
  input  logic [AW-1:0]   fetchAddr,
  input  logic            dataValid,
  input  logic            dataWrite,
  input  logic [AW-1:0]   dataAddr,
  input  logic [DW-1:0]   dataValue,
  output logic            hit
);
  logic fetchHit, dataHit, typeOk;

  always_comb begin
    typeOk   = dataWrite ? cfg.onWrite : cfg.onRead;
    fetchHit = fetchValid && cfg.onFetch &&
               (((fetchAddr ^ addrVal) & addrMask) == '0);
    dataHit  = dataValid && typeOk &&
               (((dataAddr ^ addrVal) & addrMask) == '0) &&
               (((dataValue ^ dataVal) & dataMask) == '0);
    hit      = cfg.enable && (fetchHit || dataHit);
  end
endmodule

// File: rtl/bed_datapath.sv
module bed_datapath
  import bed_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NCMP = 4,
  parameter int CW   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [RA_W-1:0]  regAddr,
  input  logic [REG_W-1:0] regWdata,
  input  logic             fetchValid,
  input  logic [AW-1:0]    fetchAddr,
  input  logic             dataValid,
  input  logic             dataWrite,
  input  logic [AW-1:0]    dataAddr,
  input  logic [DW-1:0]    dataValue,
  input  dpStrobe_t        strobe,
  output logic             hitHalt,
  output logic             hitCount,
  output logic             hitTrig,
  output logic [CW-1:0]    eventCount,
  output logic [REG_W-1:0] rdData
);
  logic [NCMP-1:0] hitVec, haltSel, countSel, trigSel;
  logic [REG_W-1:0] rdPart [NCMP];

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    localparam logic [RA_W-1:0] BASE = RA_W'(CMP_BASE + CMP_STRIDE * i);
    logic [AW-1:0] addrValR, addrMaskR;
    logic [DW-1:0] dataValR, dataMaskR;
    cmpCfg_t       cfgR;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrValR  <= '0;
        addrMaskR <= '0;
        dataValR  <= '0;
        dataMaskR <= '0;
        cfgR      <= '0;
      end else if (regWrEn) begin
        if (regAddr == BASE)      addrValR  <= regWdata[AW-1:0];
        if (regAddr == BASE + 1)  addrMaskR <= regWdata[AW-1:0];
        if (regAddr == BASE + 2)  dataValR  <= regWdata[DW-1:0];
        if (regAddr == BASE + 3)  dataMaskR <= regWdata[DW-1:0];
        if (regAddr == BASE + 4)  cfgR      <= cmpCfg_t'(regWdata[CFG_W-1:0]);
      end
    end

    bed_cmp #(.AW(AW), .DW(DW)) i_cmp (
      .cfg(cfgR), .addrVal(addrValR), .addrMask(addrMaskR),
      .dataVal(dataValR), .dataMask(dataMaskR),
      .fetchValid(fetchValid), .fetchAddr(fetchAddr),
      .dataValid(dataValid), .dataWrite(dataWrite),
      .dataAddr(dataAddr), .dataValue(dataValue),
      .hit(hitVec[i])
    );

    assign haltSel[i]  = cfgR.actHalt;
    assign countSel[i] = cfgR.actCount;
    assign trigSel[i]  = cfgR.actTrig;

    always_comb begin
      rdPart[i] = '0;
      if      (regAddr == BASE)     rdPart[i] = REG_W'(addrValR);
      else if (regAddr == BASE + 1) rdPart[i] = REG_W'(addrMaskR);
      else if (regAddr == BASE + 2) rdPart[i] = REG_W'(dataValR);
      else if (regAddr == BASE + 3) rdPart[i] = REG_W'(dataMaskR);
      else if (regAddr == BASE + 4) rdPart[i] = REG_W'(cfgR);
    end
  end

  assign hitHalt  = |(hitVec & haltSel);
  assign hitCount = |(hitVec & countSel);
  assign hitTrig  = |(hitVec & trigSel);

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NCMP; k++) rdData = rdData | rdPart[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrCount) eventCount <= '0;
    else if (strobe.incCount)     eventCount <= eventCount + 1'b1;
  end
endmodule

// File: rtl/bed_ctrl.sv
module bed_ctrl
  import bed_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [RA_W-1:0]  regAddr,
  input  logic [CW-1:0]    regWdata,
  input  logic             hitHalt,
  input  logic             hitCount,
  input  logic             hitTrig,
  input  logic [CW-1:0]    eventCount,
  output dpStrobe_t        strobe,
  output logic             haltReq,
  output logic             trigPulse,
  output logic [REG_W-1:0] rdData
);
  logic          globalEn, gateHalt;
  logic [CW-1:0] thresh;
  logic          clrHalt, clrCnt, occur, atLimit, saturated, setHalt;
  logic [CW:0]   nextCnt;

  always_comb begin
    clrHalt   = regWrEn && (regAddr == ADDR_CMD) && regWdata[0];
    clrCnt    = regWrEn && (regAddr == ADDR_CMD) && regWdata[1];
    occur     = globalEn && (hitCount || (gateHalt && hitHalt));
    atLimit   = gateHalt && (eventCount >= thresh);
    saturated = &eventCount;
    nextCnt   = {1'b0, eventCount} + 1'b1;
    setHalt   = gateHalt ? (occur && (nextCnt >= {1'b0, thresh}))
                         : (globalEn && hitHalt);
    strobe.clrCount = clrCnt;
    strobe.incCount = occur && !atLimit && !saturated;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn  <= 1'b0;
      gateHalt  <= 1'b0;
      thresh    <= '0;
      haltReq   <= 1'b0;
      trigPulse <= 1'b0;
    end else begin
      trigPulse <= globalEn && hitTrig;
      if (clrHalt)      haltReq <= 1'b0;
      else if (setHalt) haltReq <= 1'b1;
      if (regWrEn && regAddr == ADDR_CTRL) begin
        globalEn <= regWdata[0];
        gateHalt <= regWdata[1];
      end
      if (regWrEn && regAddr == ADDR_THRESH) thresh <= regWdata;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:   rdData = REG_W'({gateHalt, globalEn});
      ADDR_THRESH: rdData = REG_W'(thresh);
      ADDR_COUNT:  rdData = REG_W'(eventCount);
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/busEventDetector.sv
module busEventDetector
  import bed_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NCMP = 4,
  parameter int CW   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic [AW-1:0]    fetchAddr,
  input  logic             dataValid,
  input  logic             dataWrite,
  input  logic [AW-1:0]    dataAddr,
  input  logic [DW-1:0]    dataValue,
  input  logic             regWrEn,
  input  logic [RA_W-1:0]  regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output logic             haltReq,
  output logic             trigPulse,
  output logic [CW-1:0]    eventCount
);
  dpStrobe_t        strobe;
  logic             hitHalt, hitCount, hitTrig;
  logic [REG_W-1:0] rdDp, rdCtl;

  bed_datapath #(.AW(AW), .DW(DW), .NCMP(NCMP), .CW(CW)) i_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .dataValid(dataValid), .dataWrite(dataWrite), .dataAddr(dataAddr),
    .dataValue(dataValue), .strobe(strobe), .hitHalt(hitHalt),
    .hitCount(hitCount), .hitTrig(hitTrig), .eventCount(eventCount),
    .rdData(rdDp)
  );

  bed_ctrl #(.CW(CW)) i_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata[CW-1:0]), .hitHalt(hitHalt), .hitCount(hitCount),
    .hitTrig(hitTrig), .eventCount(eventCount), .strobe(strobe),
    .haltReq(haltReq), .trigPulse(trigPulse), .rdData(rdCtl)
  );

  assign regRdata = rdDp | rdCtl;
endmodule

// File: rtl/busEventDetector_chk.sv
module busEventDetector_chk
  import bed_pkg::*;
#(
  parameter int CW = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             fetchValid,
  input logic             dataValid,
  input logic             regWrEn,
  input logic [RA_W-1:0]  regAddr,
  input logic [REG_W-1:0] regWdata,
  input logic             haltReq,
  input logic             trigPulse,
  input logic [CW-1:0]    eventCount
);
  logic hostClrHalt, hostClrCnt, busAct;
  assign hostClrHalt = regWrEn && regAddr == ADDR_CMD && regWdata[0];
  assign hostClrCnt  = regWrEn && regAddr == ADDR_CMD && regWdata[1];
  assign busAct      = fetchValid || dataValid;

  a_r8_halt_held: assert property (@(posedge clk) disable iff (!rstN)
    haltReq && !hostClrHalt |=> haltReq);
  a_r8_halt_cleared: assert property (@(posedge clk) disable iff (!rstN)
    hostClrHalt |=> !haltReq);
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rstN)
    eventCount != $past(eventCount) |->
      (eventCount == $past(eventCount) + 1'b1 || eventCount == '0));
  a_r9_count_cleared: assert property (@(posedge clk) disable iff (!rstN)
    hostClrCnt |=> eventCount == '0);
  a_r7_trig_after_bus: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> $past(busAct));
  a_r6_halt_after_bus: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltReq) |-> $past(busAct));
endmodule

bind busEventDetector busEventDetector_chk #(.CW(CW)) i_chk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .dataValid(dataValid),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
  .haltReq(haltReq), .trigPulse(trigPulse), .eventCount(eventCount)
);

// File: tb/test_busEventDetector.sv
module test_busEventDetector;
  localparam int NC = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchValid = 1'b0, dataValid = 1'b0, dataWrite = 1'b0, regWrEn = 1'b0;
  logic [31:0] fetchAddr = '0, dataAddr = '0, dataValue = '0, regWdata = '0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regRdata;
  logic haltReq, trigPulse;
  logic [15:0] eventCount;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  busEventDetector i_busEventDetector (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .dataValid(dataValid), .dataWrite(dataWrite), .dataAddr(dataAddr),
    .dataValue(dataValue), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .haltReq(haltReq),
    .trigPulse(trigPulse), .eventCount(eventCount)
  );

  // behavioural reference model
  logic [31:0] mAV [NC], mAM [NC], mDV [NC], mDM [NC], mCfg [NC];
  logic mEn, mGate, mHalt, mTrig;
  int   mThr, mCount;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NC; i++) begin
        mAV[i] = 0; mAM[i] = 0; mDV[i] = 0; mDM[i] = 0; mCfg[i] = 0;
      end
      mEn = 0; mGate = 0; mHalt = 0; mTrig = 0; mThr = 0; mCount = 0;
    end else begin
      bit hH, hC, hT, clrH, clrC, occ, setH;
      hH = 0; hC = 0; hT = 0;
      for (int i = 0; i < NC; i++) begin
        bit m;
        m = 0;
        if (mCfg[i][0]) begin
          if (fetchValid && mCfg[i][1] && ((fetchAddr ^ mAV[i]) & mAM[i]) == 0) m = 1;
          if (dataValid && (dataWrite ? mCfg[i][3] : mCfg[i][2]) &&
              ((dataAddr ^ mAV[i]) & mAM[i]) == 0 &&
              ((dataValue ^ mDV[i]) & mDM[i]) == 0) m = 1;
        end
        if (m) begin
          hH |= mCfg[i][4]; hC |= mCfg[i][5]; hT |= mCfg[i][6];
        end
      end
      clrH = regWrEn && regAddr == 8'h01 && regWdata[0];
      clrC = regWrEn && regAddr == 8'h01 && regWdata[1];
      occ  = mEn && (hC || (mGate && hH));
      setH = mGate ? (occ && mCount + 1 >= mThr) : (mEn && hH);
      if (clrC) mCount = 0;
      else if (occ && mCount != 65535 && !(mGate && mCount >= mThr)) mCount++;
      if (clrH) mHalt = 0; else if (setH) mHalt = 1;
      mTrig = mEn && hT;
      if (regWrEn) begin
        if (regAddr == 8'h00) begin mEn = regWdata[0]; mGate = regWdata[1]; end
        if (regAddr == 8'h02) mThr = int'(regWdata[15:0]);
        for (int i = 0; i < NC; i++) begin
          int b;
          b = 16 + 8 * i;
          if (regAddr == 8'(b))     mAV[i] = regWdata;
          if (regAddr == 8'(b + 1)) mAM[i] = regWdata;
          if (regAddr == 8'(b + 2)) mDV[i] = regWdata;
          if (regAddr == 8'(b + 3)) mDM[i] = regWdata;
          if (regAddr == 8'(b + 4)) mCfg[i] = regWdata & 32'h7f;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R6: every output compared with the model one clock after each stimulus
  always @(negedge clk) if (rstN) begin
    chk("R6 haltReq", 32'(haltReq), 32'(mHalt));
    chk("R6 trigPulse", 32'(trigPulse), 32'(mTrig));
    chk("R6 eventCount", 32'(eventCount), 32'(mCount));
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; #0.5; d = regRdata;
  endtask

  task automatic fetch(input logic [31:0] a);
    fetchValid = 1; fetchAddr = a;
    @(negedge clk);
    fetchValid = 0;
  endtask

  task automatic acc(input logic w, input logic [31:0] a, input logic [31:0] v);
    dataValid = 1; dataWrite = w; dataAddr = a; dataValue = v;
    @(negedge clk);
    dataValid = 0;
  endtask

  task automatic cfgCmp(int i, logic [31:0] av, logic [31:0] am,
                        logic [31:0] dv, logic [31:0] dm, logic [31:0] cfg);
    wr(8'(16 + 8 * i), av); wr(8'(17 + 8 * i), am);
    wr(8'(18 + 8 * i), dv); wr(8'(19 + 8 * i), dm);
    wr(8'(20 + 8 * i), cfg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 halt", 32'(haltReq), 0);
    chk("R1 trig", 32'(trigPulse), 0);
    chk("R1 count", 32'(eventCount), 0);
    rd(8'h14, r); chk("R1 cfg0", r, 0);
    fetch(32'h0); acc(1, 32'h0, 32'h0);
    chk("R1 no action", 32'({haltReq, trigPulse}), 0);

    wr(8'h00, 32'h1);
    cfgCmp(0, 32'h1000, 32'hffffffff, 0, 0, 32'h13);
    fetch(32'h1004); chk("R2 miss", 32'(haltReq), 0);
    acc(0, 32'h1000, 0); chk("R2 data no fetch", 32'(haltReq), 0);
    fetch(32'h1000); chk("R2 hit", 32'(haltReq), 1);
    repeat (4) @(negedge clk);
    chk("R8 held", 32'(haltReq), 1);
    wr(8'h01, 32'h1); chk("R8 cleared", 32'(haltReq), 0);
    fetchValid = 1; fetchAddr = 32'h1000;
    wr(8'h01, 32'h1); fetchValid = 0;
    chk("R8 clear wins", 32'(haltReq), 0);

    cfgCmp(1, 32'h2000, 32'hffffffff, 32'hab, 32'hff, 32'h49);
    acc(0, 32'h2000, 32'hab); chk("R3 read ignored", 32'(trigPulse), 0);
    acc(1, 32'h2000, 32'hcd); chk("R3 data mismatch", 32'(trigPulse), 0);
    fetch(32'h2000); chk("R3 fetch ignored", 32'(trigPulse), 0);
    acc(1, 32'h2000, 32'h1ab); chk("R3 write hit", 32'(trigPulse), 1);
    @(negedge clk); chk("R7 one cycle", 32'(trigPulse), 0);
    acc(1, 32'h2000, 32'hab); chk("R7 first", 32'(trigPulse), 1);

    cfgCmp(2, 32'h3000, 32'hffffff00, 0, 0, 32'h25);
    acc(0, 32'h30ab, 32'h1234); chk("R4 masked hit", 32'(eventCount), 1);
    acc(0, 32'h31ab, 32'h1234); chk("R4 unmasked miss", 32'(eventCount), 1);
    cfgCmp(3, 32'h30ab, 32'hffffffff, 0, 0, 32'h65);
    acc(0, 32'h30ab, 0);
    chk("R5 or count", 32'(eventCount), 2);
    chk("R5 trig", 32'(trigPulse), 1);

    wr(8'h01, 32'h2); chk("R9 clear", 32'(eventCount), 0);
    dataValid = 1; dataWrite = 0; dataAddr = 32'h3000;
    wr(8'h01, 32'h2); dataValid = 0;
    chk("R9 clear wins", 32'(eventCount), 0);

    wr(8'h00, 32'h0);
    fetch(32'h1000); acc(0, 32'h30ab, 0);
    chk("R11 disabled", 32'({haltReq, trigPulse}), 0);
    chk("R11 count", 32'(eventCount), 0);

    wr(8'h02, 32'd3); wr(8'h00, 32'h3);
    fetch(32'h1000); fetch(32'h1000);
    chk("R10 below", 32'(haltReq), 0); chk("R10 count2", 32'(eventCount), 2);
    fetch(32'h1000);
    chk("R10 at thr", 32'(haltReq), 1); chk("R10 count3", 32'(eventCount), 3);
    fetch(32'h1000); chk("R10 hold", 32'(eventCount), 3);

    rd(8'h1a, r); chk("R12 data value", r, 32'hab);
    rd(8'h00, r); chk("R12 ctrl", r, 32'h3);
    rd(8'h02, r); chk("R12 thresh", r, 32'd3);
    rd(8'h03, r); chk("R12 count", r, 32'd3);
    rd(8'h01, r); chk("R12 cmd reads 0", r, 0);

    wr(8'h01, 32'h3); wr(8'h00, 32'h1);
    for (int k = 0; k < 65540; k++) acc(0, 32'h3000, 0);
    chk("R9 saturate", 32'(eventCount), 32'hffff);
    wr(8'h01, 32'h3);

    for (int k = 0; k < 3000; k++) begin
      int s;
      if (k == 1500) begin wr(8'h02, 32'd5); wr(8'h00, 32'h3); end
      s = $urandom_range(0, 9);
      fetchValid = $urandom_range(0, 1);
      fetchAddr = (s < 4) ? 32'h1000 : $urandom;
      dataValid = $urandom_range(0, 1);
      dataWrite = $urandom_range(0, 1);
      dataAddr = (s < 3) ? 32'h2000 : (s < 6) ? 32'h30ab : 32'h3000 | 32'($urandom_range(0, 511));
      dataValue = (s[0]) ? 32'hab : $urandom;
      if (s == 9) begin regWrEn = 1; regAddr = 8'h01; regWdata = 32'($urandom_range(0, 3)); end
      @(negedge clk);
      regWrEn = 0;
    end
    fetchValid = 0; dataValid = 0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule